// File: doc/BRIEF.md
# Two-Coin Vending Controller

This block is a small clocked state machine for a machine that sells a single item at 75 cents. It takes only quarters and half-dollars. Each coin arrives as a one-cycle pulse on its own detect line. The block keeps the credit paid so far and decides when the item is released and when one quarter of change goes back.

Credit is held as one of three states: idle with nothing paid, 25 cents held, or 50 cents held. The two results, dispense and change, are Mealy outputs. They rise in the same cycle as the coin pulse that completes the sale and last for that one cycle. The state then falls back to idle. The only possible over-payment is 100 cents (50 held plus a half-dollar), and that case returns exactly one quarter. The environment never raises both coin lines in the same cycle.

Top module: `vend_fsm`

## Requirements
- R1: While `rst` is high, `dispense` and `change` are low whatever the coin lines carry. After any clock edge with `rst` high, the block holds zero credit.
- R2: From zero credit, a pulse on `coin_quarter` (quarter, 25 cents) leaves 25 cents of credit, and a pulse on `coin_half` (half-dollar, 50 cents) leaves 50 cents. Neither pulse raises an output.
- R3: With 25 cents held, a quarter leaves 50 cents held and raises no output.
- R4: With 25 cents held, a half-dollar raises `dispense` alone in that cycle, and the credit returns to zero.
- R5: With 50 cents held, a quarter raises `dispense` alone in that cycle, and the credit returns to zero.
- R6: With 50 cents held, a half-dollar raises both `dispense` and `change` (one quarter back) in that cycle, and the credit returns to zero.
- R7: In a cycle with neither coin line high, both outputs are low and the credit is unchanged.
- R8: `change` is never high unless `dispense` is high in the same cycle. Both outputs depend on the present coin pulse and are high only in the cycle of that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_half | input | 1 | One-cycle pulse when a half-dollar is detected |
| coin_quarter | input | 1 | One-cycle pulse when a quarter is detected |
| dispense | output | 1 | Release the item this cycle |
| change | output | 1 | Return one quarter this cycle |

## Verification
The two outputs are Mealy: each is due in the same cycle as the coin pulse that causes it, with no register in between. A credit change shows up only at the first rising edge after the pulse. The bench therefore drives each coin on the falling edge and compares both outputs with its model a short time later, before the next rising edge. The model advances its credit only after that edge has passed. Since every cycle is compared, an output that comes early, late or lasts two cycles is reported.

// File: rtl/vend_fsm.sv
module vend_fsm (
  input  logic clk,
  input  logic rst,
  input  logic coin_half,
  input  logic coin_quarter,
  output logic dispense,
  output logic change
);

  typedef enum logic [1:0] {
    CR_NONE = 2'b00,
    CR_25   = 2'b01,
    CR_50   = 2'b10
  } credit_t;

  credit_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CR_NONE: begin
        if (coin_half)         st_d = CR_50;
        else if (coin_quarter) st_d = CR_25;
      end
      CR_25: begin
        if (coin_half)         st_d = CR_NONE;
        else if (coin_quarter) st_d = CR_50;
      end
      CR_50: begin
        if (coin_half || coin_quarter) st_d = CR_NONE;
      end
      default: st_d = CR_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= CR_NONE;
    else     st_q <= st_d;
  end

  assign dispense = !rst && (((st_q == CR_25) && coin_half) ||
                             ((st_q == CR_50) && (coin_half || coin_quarter)));
  assign change   = !rst && (st_q == CR_50) && coin_half;

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (st_q == CR_NONE))
    else $error("reset did not clear credit");

  p_quarter_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == CR_NONE) && coin_quarter && !coin_half |=> (st_q == CR_25))
    else $error("quarter from idle");

  p_sale_returns_idle_r4: assert property (@(posedge clk) disable iff (rst)
    dispense |=> (st_q == CR_NONE))
    else $error("no return to idle after sale");

  p_no_coin_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !coin_half && !coin_quarter |=> $stable(st_q))
    else $error("credit moved without coin");

  p_no_coin_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !coin_half && !coin_quarter |-> !dispense && !change)
    else $error("output without coin");

  p_change_needs_vend_r8: assert property (@(posedge clk) disable iff (rst)
    change |-> dispense)
    else $error("change without dispense");

  p_legal_state: assert property (@(posedge clk) disable iff (rst)
    st_q != 2'b11)
    else $error("unused state code reached");

endmodule

// File: tb/vend_fsm_tb.sv
module vend_fsm_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_half = 1'b0;
  logic coin_quarter = 1'b0;
  logic dispense, change;

  int total = 0;
  int bad = 0;
  int credit = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vend_fsm u_dut (
    .clk(clk), .rst(rst), .coin_half(coin_half), .coin_quarter(coin_quarter),
    .dispense(dispense), .change(change)
  );

  task automatic check(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(bit r, bit h, bit q);
    int paid;
    bit ev, ec;
    string tag;
    @(negedge clk);
    rst = r; coin_half = h; coin_quarter = q;
    #1;
    paid = credit + (h ? 50 : 0) + (q ? 25 : 0);
    if (r) begin
      ev = 0; ec = 0; tag = "R1";
    end else begin
      ev = (paid >= 75);
      ec = (paid == 100);
      if (!h && !q)        tag = "R7";
      else if (credit == 0) tag = "R2";
      else if (credit == 25) tag = q ? "R3" : "R4";
      else                  tag = q ? "R5" : "R6";
    end
    check(tag, dispense, ev, "dispense");
    check(tag, change, ec, "change");
    if (change && !dispense) check("R8", 1'b1, 1'b0, "change alone");
    @(posedge clk);
    if (r) credit = 0;
    else if (paid >= 75) credit = 0;
    else credit = paid;
  endtask

  initial begin
    step(1, 0, 0);
    step(1, 1, 0);
    step(1, 0, 1);
    step(0, 0, 0);
    // R2 then R3 then R5
    step(0, 0, 1); step(0, 0, 0); step(0, 0, 1); step(0, 0, 1);
    // R2 half then R6
    step(0, 1, 0); step(0, 1, 0);
    // R3 path then R6
    step(0, 0, 1); step(0, 0, 1); step(0, 0, 0); step(0, 1, 0);
    // R4
    step(0, 0, 1); step(0, 1, 0);
    // R5 from half
    step(0, 1, 0); step(0, 0, 0); step(0, 0, 1);
    // R8: one-cycle outputs, idle afterwards
    step(0, 0, 0); step(0, 0, 0);
    // R1 mid-credit reset with coin present
    step(0, 1, 0); step(1, 1, 0); step(0, 0, 1); step(0, 1, 0);
    // back-to-back coins
    for (int i = 0; i < 40; i++) begin
      int k = (i * 7 + 3) % 5;
      step(0, k == 1 || k == 3, k == 2);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule